// File: doc/BRIEF.md
# PC Card Host Cycle Controller

This block turns a single internal access request into one complete host-side PC Card socket cycle. A request gives the card address, the transfer direction, whether the target is memory or I/O space, whether memory is attribute or common space, the access width and the width of the card's data port. The block then drives the socket address, the space-select line, the two active-low card enables and the matching command strobe, and it sets the data transceiver direction.

Each cycle runs through three phases. A setup phase presents address, space select and card enables with no strobe. A strobe phase lasts at least a programmed number of cycles and is stretched for as long as the card holds its wait line. A hold phase removes the strobe while address and enables stay put. The card's wait line passes through a two-flop synchronizer before the sequencer uses it. At the end of the cycle the block returns read data and a one-cycle done pulse. A 16-bit access at an odd address is refused with a one-cycle error pulse, and no socket cycle is run.

Top module: `pccard_cycle_ctrl`

## Requirements
- R1: `sock_addr` carries all 26 bits of the accepted `req_addr`, with host bit 0 on socket line 0, and stays constant from the first setup cycle to the last hold cycle.
- R2: With `port_wide`=1, a 16-bit access (`req_wide`=1, `req_addr[0]`=0) drives both enables low, an 8-bit access at an odd address drives `sock_ce2_n` low and `sock_ce1_n` high, and an 8-bit access at an even address drives `sock_ce1_n` low and `sock_ce2_n` high.
- R3: With `port_wide`=0, every access drives `sock_ce1_n` low and keeps `sock_ce2_n` high, whatever the access size and address bit 0.
- R4: While `busy` is low, both card enables, `sock_reg_n` and all four strobes are high, and `sock_dout_en` is low.
- R5: During a cycle, `sock_reg_n` is low for an attribute memory access (`req_attr`=1) and for every I/O access (`req_io`=1), even when `req_attr`=0. It is high for a common memory access.
- R6: Only in the strobe phase is exactly one strobe low: `sock_oe_n` for a memory read, `sock_we_n` for a memory write, `sock_iord_n` for an I/O read and `sock_iowr_n` for an I/O write. An I/O strobe is low only together with a low `sock_reg_n` and at least one low card enable.
- R7: An accepted request raises `busy` for SETUP_CYC setup cycles, then at least max(`strobe_min`,1) strobe cycles, then HOLD_CYC hold cycles. `done` is high for the single cycle after the last hold cycle, and `busy` is low in that cycle.
- R8: `sock_wait_n` low is sampled through two flip-flops. Once the minimum has run out, the strobe phase lasts while the synchronized wait is asserted. After `sock_wait_n` rises, the strobe stays low for two more clock edges and ends on the third.
- R9: `sock_dir` is low during write cycles and high during read cycles and when idle. During a write cycle `sock_dout_en` is high and socket data line k carries `req_wdata` bit 15-k, so line 0 is the most significant bit.
- R10: For a read, `rd_data` holds the socket data sampled on the clock edge that ends the strobe phase, with line k mapped to bit 15-k. It is valid when `done` is high, and writes leave it unchanged.
- R11: A request with `req_wide`=1 and `req_addr[0]`=1 produces `err` high for one cycle and no `busy`, no enable, no strobe and no `done`.
- R12: `req_valid` has no effect while `busy` is high. The running cycle keeps its address, and no second cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | 26 | Card address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_attr | input | 1 | 1 = attribute memory |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| port_wide | input | 1 | 1 = 16-bit card port, 0 = 8-bit |
| req_wdata | input | 16 | Write data, bit 15 most significant |
| strobe_min | input | 8 | Minimum strobe cycles, 0 treated as 1 |
| busy | output | 1 | Socket cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle misaligned request pulse |
| rd_data | output | 16 | Captured read data |
| sock_addr | output | 26 | Socket address |
| sock_reg_n | output | 1 | Attribute / I/O space select, active low |
| sock_ce1_n | output | 1 | Even byte enable, active low |
| sock_ce2_n | output | 1 | Odd byte enable, active low |
| sock_oe_n | output | 1 | Memory read strobe, active low |
| sock_we_n | output | 1 | Memory write strobe, active low |
| sock_iord_n | output | 1 | I/O read strobe, active low |
| sock_iowr_n | output | 1 | I/O write strobe, active low |
| sock_dir | output | 1 | Transceiver direction, high = read |
| sock_dout | output | 16 | Socket write data, line 0 most significant |
| sock_dout_en | output | 1 | Socket data drive enable |
| sock_din | input | 16 | Socket read data, line 0 most significant |
| sock_wait_n | input | 1 | Card wait, active low |

## Verification
Some properties are checked on every clock. Enables and strobes stay quiet when idle. An I/O strobe never appears without the space select and a card enable. At most one strobe is low at a time. An 8-bit port never gets its odd enable. The address holds still through a cycle. The strobe phase cannot end while the synchronized wait is asserted or before the minimum runs out. `done` only follows a hold cycle and `err` never overlaps a cycle. Other behaviour only the bench's scenarios can show: the enable pattern chosen for each width and address combination, the exact two-edge latency after the wait is released, the bit-reversed data mapping, the captured read value, and requests being ignored while busy.

// File: rtl/pccard_pkg.sv
`timescale 1ns/1ps
package pccard_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;

   typedef struct packed {
      logic write;
      logic io;
      logic attr;
      logic wide;
      logic port16;
   } req_kind_t;

endpackage

// File: rtl/pccard_wait_sync.sv
`timescale 1ns/1ps
module pccard_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_n_raw,
   output logic wait_on
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pccard_wait_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= wait_n_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign wait_on = ~chain[STAGES-1];

endmodule

// File: rtl/pccard_lane_decode.sv
`timescale 1ns/1ps
module pccard_lane_decode (
   input  logic active,
   input  logic a0,
   input  logic wide,
   input  logic port16,
   output logic ce1_n,
   output logic ce2_n
);

   logic even_lane;
   logic odd_lane;

   always_comb begin
      even_lane = 1'b0;
      odd_lane  = 1'b0;
      if (active) begin
         if (!port16) begin
            even_lane = 1'b1;
         end else if (wide) begin
            even_lane = 1'b1;
            odd_lane  = 1'b1;
         end else if (a0) begin
            odd_lane  = 1'b1;
         end else begin
            even_lane = 1'b1;
         end
      end
   end

   assign ce1_n = ~even_lane;
   assign ce2_n = ~odd_lane;

endmodule

// File: rtl/pccard_cycle_seq.sv
`timescale 1ns/1ps
module pccard_cycle_seq
   import pccard_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int HOLD_CYC  = 1,
   parameter int CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] strobe_min,
   input  logic             wait_on,
   output phase_e           phase,
   output logic             strobe_exit,
   output logic             done
);

   localparam int CNT_SPAN = 1 << CNT_W;

   generate
      if (SETUP_CYC < 1 || SETUP_CYC > CNT_SPAN) begin : g_bad_setup
         $error("pccard_cycle_seq: SETUP_CYC out of range");
      end
      if (HOLD_CYC < 1 || HOLD_CYC > CNT_SPAN) begin : g_bad_hold
         $error("pccard_cycle_seq: HOLD_CYC out of range");
      end
   endgenerate

   localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_TOP    = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] min_last;

   assign min_last    = (strobe_min == '0) ? '0 : strobe_min - CNT_W'(1);
   assign strobe_exit = (phase == PH_STROBE) && (cnt >= min_last) && !wait_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_SETUP;
                  cnt   <= '0;
               end
            end
            PH_SETUP: begin
               if (cnt == SETUP_LAST) begin
                  phase <= PH_STROBE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_STROBE: begin
               if (strobe_exit) begin
                  phase <= PH_HOLD;
                  cnt   <= '0;
               end else if (cnt != CNT_TOP) begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_HOLD: begin
               if (cnt == HOLD_LAST) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R8
   wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STROBE && wait_on) |=> (phase == PH_STROBE));

   // R7
   strobe_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STROBE && cnt < min_last) |=> (phase == PH_STROBE));

   // R7
   done_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(phase) == PH_HOLD && phase == PH_IDLE));

endmodule

// File: rtl/pccard_cycle_ctrl.sv
`timescale 1ns/1ps
module pccard_cycle_ctrl
   import pccard_pkg::*;
#(
   parameter int ADDR_W      = 26,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 8,
   parameter int SETUP_CYC   = 2,
   parameter int HOLD_CYC    = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_attr,
   input  logic              req_wide,
   input  logic              port_wide,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]  strobe_min,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] sock_addr,
   output logic              sock_reg_n,
   output logic              sock_ce1_n,
   output logic              sock_ce2_n,
   output logic              sock_oe_n,
   output logic              sock_we_n,
   output logic              sock_iord_n,
   output logic              sock_iowr_n,
   output logic              sock_dir,
   output logic [DATA_W-1:0] sock_dout,
   output logic              sock_dout_en,
   input  logic [DATA_W-1:0] sock_din,
   input  logic              sock_wait_n
);

   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("pccard_cycle_ctrl: socket data path must be 16 bits");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pccard_cycle_ctrl: ADDR_W too small");
      end
   endgenerate

   // ---------------- request latch ----------------
   logic              accept;
   logic              misaligned;
   logic              start;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [CNT_W-1:0]  min_q;
   req_kind_t         kind_q;
   logic              err_q;
   logic [DATA_W-1:0] rdata_q;

   phase_e phase;
   logic   strobe_exit;
   logic   wait_on;
   logic   active;
   logic   in_strobe;

   assign active     = (phase != PH_IDLE);
   assign in_strobe  = (phase == PH_STROBE);
   assign accept     = req_valid && !active;
   assign misaligned = req_wide && req_addr[0];
   assign start      = accept && !misaligned;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         min_q   <= '0;
         kind_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= accept && misaligned;
         if (start) begin
            addr_q       <= req_addr;
            wdata_q      <= req_wdata;
            min_q        <= strobe_min;
            kind_q.write <= req_write;
            kind_q.io    <= req_io;
            kind_q.attr  <= req_attr;
            kind_q.wide  <= req_wide;
            kind_q.port16 <= port_wide;
         end
      end
   end

   // ---------------- wait synchronizer ----------------
   pccard_wait_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .wait_n_raw (sock_wait_n),
      .wait_on    (wait_on)
   );

   // ---------------- phase sequencer ----------------
   pccard_cycle_seq #(
      .SETUP_CYC (SETUP_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .strobe_min  (min_q),
      .wait_on     (wait_on),
      .phase       (phase),
      .strobe_exit (strobe_exit),
      .done        (done)
   );

   // ---------------- byte lane enables ----------------
   pccard_lane_decode u_lanes (
      .active (active),
      .a0     (addr_q[0]),
      .wide   (kind_q.wide),
      .port16 (kind_q.port16),
      .ce1_n  (sock_ce1_n),
      .ce2_n  (sock_ce2_n)
   );

   // ---------------- space select and strobes ----------------
   logic reg_on;
   logic any_ce;

   assign reg_on = active && (kind_q.attr || kind_q.io);
   assign any_ce = !(sock_ce1_n && sock_ce2_n);

   assign sock_reg_n  = ~reg_on;
   assign sock_oe_n   = ~(in_strobe && !kind_q.io && !kind_q.write);
   assign sock_we_n   = ~(in_strobe && !kind_q.io &&  kind_q.write);
   assign sock_iord_n = ~(in_strobe && kind_q.io && !kind_q.write && reg_on && any_ce);
   assign sock_iowr_n = ~(in_strobe && kind_q.io &&  kind_q.write && reg_on && any_ce);

   assign sock_dir     = active ? ~kind_q.write : 1'b1;
   assign sock_dout_en = active && kind_q.write;
   assign sock_addr    = addr_q;

   // ---------------- data line ordering (line 0 = MSB) ----------------
   logic [DATA_W-1:0] din_host;

   generate
      for (genvar k = 0; k < DATA_W; k++) begin : g_lane_bit
         assign sock_dout[k] = wdata_q[DATA_W-1-k];
         assign din_host[DATA_W-1-k] = sock_din[k];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            rdata_q <= '0;
      else if (strobe_exit && !kind_q.write) rdata_q <= din_host;
   end

   assign rd_data = rdata_q;
   assign err     = err_q;
   assign busy    = active;

   // ---------------- assertions ----------------
   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sock_ce1_n && sock_ce2_n && sock_reg_n && sock_oe_n &&
                 sock_we_n && sock_iord_n && sock_iowr_n && !sock_dout_en));

   // R6
   io_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sock_iord_n || !sock_iowr_n) |-> (!sock_reg_n && !(sock_ce1_n && sock_ce2_n)));

   // R6
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~sock_oe_n, ~sock_we_n, ~sock_iord_n, ~sock_iowr_n}));

   // R3
   narrow_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !kind_q.port16) |-> sock_ce2_n);

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sock_addr));

   // R11
   err_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !done));

endmodule

// File: tb/sim_pccard_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_pccard_cycle_ctrl;

   localparam int SETUP = 2;
   localparam int HOLD  = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [25:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_io = 1'b0;
   logic        req_attr = 1'b0;
   logic        req_wide = 1'b0;
   logic        port_wide = 1'b0;
   logic [15:0] req_wdata = '0;
   logic [7:0]  strobe_min = '0;
   logic [15:0] sock_din = '0;
   logic        sock_wait_n = 1'b1;

   logic        busy, done, err;
   logic [15:0] rd_data;
   logic [25:0] sock_addr;
   logic        sock_reg_n, sock_ce1_n, sock_ce2_n;
   logic        sock_oe_n, sock_we_n, sock_iord_n, sock_iowr_n;
   logic        sock_dir, sock_dout_en;
   logic [15:0] sock_dout;

   int checks = 0;
   int fails  = 0;
   bit run_cmp = 1'b0;

   always #4 clk = ~clk;

   pccard_cycle_ctrl #(
      .SETUP_CYC (SETUP),
      .HOLD_CYC  (HOLD)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_io(req_io), .req_attr(req_attr),
      .req_wide(req_wide), .port_wide(port_wide), .req_wdata(req_wdata),
      .strobe_min(strobe_min), .busy(busy), .done(done), .err(err),
      .rd_data(rd_data), .sock_addr(sock_addr), .sock_reg_n(sock_reg_n),
      .sock_ce1_n(sock_ce1_n), .sock_ce2_n(sock_ce2_n), .sock_oe_n(sock_oe_n),
      .sock_we_n(sock_we_n), .sock_iord_n(sock_iord_n), .sock_iowr_n(sock_iowr_n),
      .sock_dir(sock_dir), .sock_dout(sock_dout), .sock_dout_en(sock_dout_en),
      .sock_din(sock_din), .sock_wait_n(sock_wait_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] flip16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   // ---------------- behavioural reference model ----------------
   int          m_phase;   // 0 idle, 1 setup, 2 strobe, 3 hold
   int          m_cnt;
   logic [25:0] m_addr;
   bit          m_write, m_io, m_attr, m_wide, m_p16;
   logic [15:0] m_wdata, m_rdata;
   int          m_min;
   bit          m_done, m_err;
   bit          wq[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
         m_write = 0; m_io = 0; m_attr = 0; m_wide = 0; m_p16 = 0; m_min = 0;
         m_done = 0; m_err = 0;
         wq = '{1'b1, 1'b1};
      end else begin
         bit seen_wait_n;
         seen_wait_n = wq[0];
         wq.push_back(sock_wait_n);
         void'(wq.pop_front());
         m_done = 0;
         m_err  = 0;
         case (m_phase)
            0: if (req_valid) begin
                  if (req_wide && req_addr[0]) m_err = 1;
                  else begin
                     m_addr = req_addr; m_write = req_write; m_io = req_io;
                     m_attr = req_attr; m_wide = req_wide; m_p16 = port_wide;
                     m_wdata = req_wdata; m_min = strobe_min;
                     m_phase = 1; m_cnt = 0;
                  end
               end
            1: if (m_cnt == SETUP-1) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
            2: begin
                  int need;
                  need = (m_min == 0) ? 1 : m_min;
                  if (m_cnt + 1 >= need && seen_wait_n) begin
                     if (!m_write) m_rdata = flip16(sock_din);
                     m_phase = 3; m_cnt = 0;
                  end else m_cnt++;
               end
            default: if (m_cnt == HOLD-1) begin m_phase = 0; m_cnt = 0; m_done = 1; end else m_cnt++;
         endcase
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         bit act, stb, e1, e2, ereg;
         string ce_tag;
         act = (m_phase != 0);
         stb = (m_phase == 2);
         e1 = 1; e2 = 1;
         if (act) begin
            if (!m_p16)      begin e1 = 0; e2 = 1; end
            else if (m_wide) begin e1 = 0; e2 = 0; end
            else if (m_addr[0]) begin e1 = 1; e2 = 0; end
            else             begin e1 = 0; e2 = 1; end
         end
         ce_tag = !act ? "R4 enables idle" : (m_p16 ? "R2 enables 16-bit port" : "R3 enables 8-bit port");
         ereg = act ? !(m_attr || m_io) : 1'b1;
         chk(busy == act, "R7 busy", busy, act);
         chk({sock_ce1_n, sock_ce2_n} == {e1, e2}, ce_tag, {sock_ce1_n, sock_ce2_n}, {e1, e2});
         chk(sock_reg_n == ereg, "R5 space select", sock_reg_n, ereg);
         chk({sock_oe_n, sock_we_n, sock_iord_n, sock_iowr_n} ==
             {!(stb && !m_io && !m_write), !(stb && !m_io && m_write),
              !(stb && m_io && !m_write), !(stb && m_io && m_write)},
             "R6 strobes", {sock_oe_n, sock_we_n, sock_iord_n, sock_iowr_n},
             {!(stb && !m_io && !m_write), !(stb && !m_io && m_write),
              !(stb && m_io && !m_write), !(stb && m_io && m_write)});
         chk(sock_dir == (act ? !m_write : 1'b1), "R9 direction", sock_dir, act ? !m_write : 1'b1);
         chk(sock_dout_en == (act && m_write), "R9 data enable", sock_dout_en, act && m_write);
         if (act && m_write) chk(sock_dout == flip16(m_wdata), "R9 data lines", sock_dout, flip16(m_wdata));
         if (act) chk(sock_addr == m_addr, "R1 address", sock_addr, m_addr);
         chk(done == m_done, "R7 done", done, m_done);
         chk(err == m_err, "R11 error", err, m_err);
         chk(rd_data == m_rdata, "R10 read data", rd_data, m_rdata);
      end
   end

   task automatic issue(input logic [25:0] a, input bit wr, input bit io, input bit at,
                        input bit wd, input bit p16, input logic [15:0] wdat, input logic [7:0] mn);
      req_addr = a; req_write = wr; req_io = io; req_attr = at; req_wide = wd;
      port_wide = p16; req_wdata = wdat; strobe_min = mn;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run_cmp = 1'b1;
      @(negedge clk);
      // R4 reset state
      chk(!busy && sock_ce1_n && sock_ce2_n && sock_reg_n && sock_oe_n, "R4 reset idle",
          {busy, sock_ce1_n, sock_ce2_n, sock_reg_n, sock_oe_n}, 5'b01111);

      sock_din = 16'hA5C3;
      issue(26'h0001234, 0, 0, 0, 1, 1, 16'h0, 8'd3);         // common mem read, 16-bit
      chk(rd_data == flip16(16'hA5C3), "R10 read capture", rd_data, flip16(16'hA5C3));
      issue(26'h0000101, 1, 0, 1, 0, 1, 16'h8001, 8'd2);     // attr write, 8-bit odd
      sock_din = 16'h0F0F;
      issue(26'h0000200, 0, 1, 0, 0, 1, 16'h0, 8'd1);         // I/O read, attr=0, 8-bit even
      issue(26'h0000400, 1, 1, 0, 1, 0, 16'h1234, 8'd2);     // I/O write, 8-bit port, wide
      sock_din = 16'h7E81;
      issue(26'h0000011, 0, 0, 0, 0, 0, 16'h0, 8'd0);         // 8-bit port, odd, min 0
      issue(26'h3FFFFFE, 0, 0, 1, 0, 1, 16'h0, 8'd4);         // top address attr read
      issue(26'h0000003, 0, 0, 0, 1, 1, 16'h0, 8'd2);         // misaligned wide
      chk(!busy && sock_oe_n, "R11 no cycle after reject", {busy, sock_oe_n}, 2'b01);

      // R9 most significant bit on line 0 during a write
      req_addr = 26'h0000020; req_write = 1; req_io = 0; req_attr = 0; req_wide = 1;
      port_wide = 1; req_wdata = 16'h8000; strobe_min = 8'd2; req_valid = 1;
      @(negedge clk); req_valid = 0;
      while (sock_we_n) @(negedge clk);
      chk(sock_dout[0] == 1'b1 && sock_dout[15] == 1'b0, "R9 line 0 is MSB", sock_dout, 16'h0001);
      while (busy) @(negedge clk);
      @(negedge clk);

      // R8 wait stretching and release latency
      sock_wait_n = 1'b0;
      sock_din = 16'h3C3C;
      req_addr = 26'h0000044; req_write = 0; req_io = 0; req_attr = 0; req_wide = 1;
      port_wide = 1; strobe_min = 8'd1; req_valid = 1;
      @(negedge clk); req_valid = 0;
      while (sock_oe_n) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(!sock_oe_n, "R8 strobe held by wait", sock_oe_n, 1'b0);
      sock_wait_n = 1'b1;
      @(negedge clk);
      chk(!sock_oe_n, "R8 release edge 1", sock_oe_n, 1'b0);
      @(negedge clk);
      chk(!sock_oe_n, "R8 release edge 2", sock_oe_n, 1'b0);
      @(negedge clk);
      chk(sock_oe_n, "R8 strobe ends on edge 3", sock_oe_n, 1'b1);
      while (busy) @(negedge clk);
      @(negedge clk);

      // R12 request during a cycle is ignored
      req_addr = 26'h0000100; req_write = 0; req_io = 1; req_attr = 1; req_wide = 0;
      port_wide = 1; strobe_min = 8'd5; req_valid = 1;
      @(negedge clk); req_valid = 0;
      @(negedge clk);
      req_addr = 26'h0002222; req_valid = 1;
      @(negedge clk); req_valid = 0;
      @(negedge clk);
      chk(sock_addr == 26'h0000100 && busy, "R12 address kept", sock_addr, 26'h0000100);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(!busy, "R12 no second cycle", busy, 1'b0);

      issue(26'h0000300, 1, 0, 0, 0, 1, 16'hBEEF, 8'd1);     // common write, 8-bit even
      @(negedge clk);
      run_cmp = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule